// File: doc/BRIEF.md
# Byte-Wide DMA Channel Register File

This block is the host-facing register file of a four-channel, legacy-style DMA controller. A processor reaches it through a narrow byte bus: chip select, separate read and write strobes, a short offset and eight data bits. Every channel keeps a 16-bit base address, a current address, a base count and a current count. Each of these is reached through one 8-bit port as two back-to-back byte accesses. A single low/high pointer flip-flop, shared by all channels, decides which half each access hits. Command, request, status, per-channel mode and per-channel mask state complete the register set. Master clear and clear-all-masks commands are also supported.

A minimal transfer stub is built in. A one-cycle step on an unmasked channel advances the current address up or down, as the channel's mode selects, and decrements the current count. When the count is already zero, the step raises terminal count. At terminal count the channel either reloads from its base registers (autoinit) or masks itself. A parameter moves every port to even offsets on a word-spaced bus, so the same logic can sit at a second controller position.

Top module: `dma_regif`

## Requirements
- R1: After reset all four mask bits are set (mask_o = 4'hF), the status register reads 0x00 and the byte pointer selects the low byte.
- R2: Port offset 2n is the address port and offset 2n+1 the count port of channel n (n = 0..3). A write loads both the base and the current copy of the selected byte. A read returns the current copy, low byte when the pointer is clear and high byte when it is set.
- R3: Each byte read or write of an address or count port toggles the pointer. Any write to offset 0x0C clears it.
- R4: A write to offset 0x0A updates the mask of the channel given by data bits 1:0. Bit 2 set masks the channel and bit 2 clear unmasks it.
- R5: A write to offset 0x0F loads mask_o from data bits 3:0. Any write to offset 0x0E clears all four mask bits.
- R6: A write to offset 0x0D (master clear) sets all mask bits, clears the pointer and clears the command, request and status registers. Reading offset 0x0D returns 0x00.
- R7: A step on an enabled channel decrements the current count by one. It increments the current address when mode bit 5 is 0 and decrements it when bit 5 is 1. The mode is written at offset 0x0B, and data bits 1:0 choose the channel.
- R8: A step while the current count is 0x0000 is terminal count. The tc_o bit pulses, and the status bit for the channel is set. With mode bit 4 (autoinit) set, current address and count reload from their base copies. Otherwise the count wraps to 0xFFFF and the channel's mask bit is set.
- R9: The status register at offset 0x08 reads terminal-count flags in bits 3:0 and pending software requests in bits 7:4. A read clears bits 3:0.
- R10: A write to offset 0x09 sets (data bit 2 = 1) or clears (bit 2 = 0) the request of the channel given by data bits 1:0. Terminal count on a channel clears its request.
- R11: A step is ignored when its channel is masked or when command bit 2 (controller disable, written at offset 0x08) is set.
- R12: With WORD_SPACED = 1 every offset is doubled on a 5-bit address, so 0x18 clears the pointer and 0x1E loads all masks, and any access to an odd address is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Chip select |
| wr_en | input | 1 | Byte write strobe |
| rd_en | input | 1 | Byte read strobe |
| addr | input | AW (4 or 5) | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid while a read is selected |
| step_valid | input | 1 | Transfer stub: advance one channel this cycle |
| step_ch | input | 2 | Channel advanced by step_valid |
| mask_o | output | 4 | Per-channel mask bits |
| tc_o | output | 4 | Per-channel terminal-count pulse |
| cmd_o | output | 8 | Command register |
| chan_mode_o | output | 24 | Mode bits 7:2 of each channel, channel n in bits 6n+5:6n |

## Verification
The hardest state to reach is the interaction between terminal count and the shared pointer and mask state. The stimulus programs a count of two and unmasks the channel, then steps it past zero. It then confirms the self-mask, the wrapped count, the status flag and the clear-on-read by paired byte reads. An autoinit channel with a decrementing address is driven through the same boundary to show the reload. The pointer's reset by master clear is made visible by leaving the pointer half-way through a pair first: a following read must then return the low byte.

// File: rtl/dma_regif_pkg.sv
package dma_regif_pkg;

    localparam int NUM_CH = 4;
    localparam int REG_W  = 16;

    localparam logic [3:0] OFF_CMD     = 4'h8;
    localparam logic [3:0] OFF_REQ     = 4'h9;
    localparam logic [3:0] OFF_MASK1   = 4'hA;
    localparam logic [3:0] OFF_MODE    = 4'hB;
    localparam logic [3:0] OFF_PTRCLR  = 4'hC;
    localparam logic [3:0] OFF_MCLR    = 4'hD;
    localparam logic [3:0] OFF_MASKCLR = 4'hE;
    localparam logic [3:0] OFF_MASKALL = 4'hF;

    // Mode byte bits 7:2; bits 1:0 of the written byte select the channel.
    typedef struct packed {
        logic [1:0] xfer_mode;
        logic       addr_dec;
        logic       autoinit;
        logic [1:0] xfer_type;
    } chan_mode_t;

    localparam int MODE_W = $bits(chan_mode_t);

    function automatic logic is_chan_port(input logic [3:0] off);
        return ~off[3];
    endfunction

    function automatic logic [7:0] pick_byte(input logic [REG_W-1:0] v, input logic hi);
        return hi ? v[15:8] : v[7:0];
    endfunction

endpackage

// File: rtl/dma_regif_ptr.sv
module dma_regif_ptr (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic toggle,
    output logic hi
);
    always_ff @(posedge clk) begin
        if (rst || clr) hi <= 1'b0;
        else if (toggle) hi <= ~hi;
    end

    assert_ptr_clear_R3: assert property (@(posedge clk) disable iff (rst)
        clr |=> !hi);
    assert_ptr_toggle_R3: assert property (@(posedge clk) disable iff (rst)
        (toggle && !clr) |=> (hi != $past(hi)));
endmodule

// File: rtl/dma_regif_chan.sv
module dma_regif_chan
    import dma_regif_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_addr,
    input  logic             wr_cnt,
    input  logic             hi,
    input  logic [7:0]       wdata,
    input  logic             mode_we,
    input  chan_mode_t       mode_in,
    input  logic             step,
    output logic [REG_W-1:0] cur_addr,
    output logic [REG_W-1:0] cur_cnt,
    output logic             tc,
    output chan_mode_t       mode
);
    logic [REG_W-1:0] base_addr, base_cnt;

    assign tc = step && (cur_cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            base_addr <= '0;
            cur_addr  <= '0;
            base_cnt  <= '0;
            cur_cnt   <= '0;
            mode      <= '0;
        end else begin
            if (mode_we) mode <= mode_in;
            if (wr_addr) begin
                if (hi) begin
                    base_addr[15:8] <= wdata;
                    cur_addr[15:8]  <= wdata;
                end else begin
                    base_addr[7:0] <= wdata;
                    cur_addr[7:0]  <= wdata;
                end
            end else if (step) begin
                if (tc && mode.autoinit) cur_addr <= base_addr;
                else if (mode.addr_dec)  cur_addr <= cur_addr - 1'b1;
                else                     cur_addr <= cur_addr + 1'b1;
            end
            if (wr_cnt) begin
                if (hi) begin
                    base_cnt[15:8] <= wdata;
                    cur_cnt[15:8]  <= wdata;
                end else begin
                    base_cnt[7:0] <= wdata;
                    cur_cnt[7:0]  <= wdata;
                end
            end else if (step) begin
                if (tc && mode.autoinit) cur_cnt <= base_cnt;
                else                     cur_cnt <= cur_cnt - 1'b1;
            end
        end
    end

    assert_autoinit_reload_R8: assert property (@(posedge clk) disable iff (rst)
        (step && cur_cnt == '0 && mode.autoinit && !wr_cnt && !mode_we)
        |=> cur_cnt == $past(base_cnt));
    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (!step && !wr_addr && !wr_cnt) |=> ($stable(cur_addr) && $stable(cur_cnt)));
endmodule

// File: rtl/dma_regif.sv
module dma_regif
    import dma_regif_pkg::*;
#(
    parameter bit WORD_SPACED = 1'b0,
    localparam int AW = WORD_SPACED ? 5 : 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cs,
    input  logic                     wr_en,
    input  logic                     rd_en,
    input  logic [AW-1:0]            addr,
    input  logic [7:0]               wdata,
    output logic [7:0]               rdata,
    input  logic                     step_valid,
    input  logic [1:0]               step_ch,
    output logic [NUM_CH-1:0]        mask_o,
    output logic [NUM_CH-1:0]        tc_o,
    output logic [7:0]               cmd_o,
    output logic [NUM_CH*MODE_W-1:0] chan_mode_o
);
    logic [3:0] off;
    logic       hit;

    generate
        if (WORD_SPACED) begin : g_word
            assign off = addr[4:1];
            assign hit = cs & ~addr[0];
        end else begin : g_byte
            assign off = addr[3:0];
            assign hit = cs;
        end
    endgenerate

    logic wr_s, rd_s, chan_acc, mclr, ptr_hi;
    logic [1:0] sel_ch;
    assign wr_s     = hit && wr_en;
    assign rd_s     = hit && rd_en && !wr_en;
    assign chan_acc = is_chan_port(off) && (wr_s || rd_s);
    assign sel_ch   = off[2:1];
    assign mclr     = wr_s && (off == OFF_MCLR);

    dma_regif_ptr u_ptr (
        .clk    (clk),
        .rst    (rst),
        .clr    (mclr || (wr_s && off == OFF_PTRCLR)),
        .toggle (chan_acc),
        .hi     (ptr_hi)
    );

    logic [NUM_CH-1:0] mask_q, req_q, tcs_q, step_en;
    logic [7:0]        cmd_q;
    logic [REG_W-1:0]  cur_a [NUM_CH];
    logic [REG_W-1:0]  cur_c [NUM_CH];
    chan_mode_t        mode_q [NUM_CH];
    logic [NUM_CH-1:0] auto_v;

    genvar i;
    generate
        for (i = 0; i < NUM_CH; i++) begin : g_ch
            assign step_en[i] = step_valid && (step_ch == i) && !mask_q[i] && !cmd_q[2];
            dma_regif_chan u_chan (
                .clk      (clk),
                .rst      (rst),
                .wr_addr  (wr_s && is_chan_port(off) && sel_ch == i && !off[0]),
                .wr_cnt   (wr_s && is_chan_port(off) && sel_ch == i && off[0]),
                .hi       (ptr_hi),
                .wdata    (wdata),
                .mode_we  (wr_s && off == OFF_MODE && wdata[1:0] == i),
                .mode_in  (chan_mode_t'(wdata[7:2])),
                .step     (step_en[i]),
                .cur_addr (cur_a[i]),
                .cur_cnt  (cur_c[i]),
                .tc       (tc_o[i]),
                .mode     (mode_q[i])
            );
            assign auto_v[i] = mode_q[i].autoinit;
            assign chan_mode_o[i*MODE_W +: MODE_W] = mode_q[i];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || mclr) begin
            mask_q <= '1;
            req_q  <= '0;
            tcs_q  <= '0;
            cmd_q  <= '0;
        end else begin
            if (wr_s && off == OFF_CMD) cmd_q <= wdata;

            if (wr_s && off == OFF_MASK1)
                mask_q <= (mask_q & ~(4'b1 << wdata[1:0])) | ({3'b0, wdata[2]} << wdata[1:0])
                          | (tc_o & ~auto_v);
            else if (wr_s && off == OFF_MASKCLR)
                mask_q <= tc_o & ~auto_v;
            else if (wr_s && off == OFF_MASKALL)
                mask_q <= wdata[3:0] | (tc_o & ~auto_v);
            else
                mask_q <= mask_q | (tc_o & ~auto_v);

            if (wr_s && off == OFF_REQ)
                req_q <= ((req_q & ~(4'b1 << wdata[1:0])) | ({3'b0, wdata[2]} << wdata[1:0])) & ~tc_o;
            else
                req_q <= req_q & ~tc_o;

            tcs_q <= ((rd_s && off == OFF_CMD) ? '0 : tcs_q) | tc_o;
        end
    end

    always_comb begin
        rdata = 8'h00;
        if (rd_s) begin
            if (is_chan_port(off))
                rdata = pick_byte(off[0] ? cur_c[sel_ch] : cur_a[sel_ch], ptr_hi);
            else if (off == OFF_CMD)
                rdata = {req_q, tcs_q};
        end
    end

    assign mask_o = mask_q;
    assign cmd_o  = cmd_q;

    assert_mclr_R6: assert property (@(posedge clk) disable iff (rst)
        mclr |=> (mask_o == 4'hF && req_q == '0 && cmd_o == 8'h00));
    assert_status_clear_R9: assert property (@(posedge clk) disable iff (rst)
        (rd_s && off == OFF_CMD && tc_o == '0) |=> tcs_q == '0);
    assert_masked_no_tc_R11: assert property (@(posedge clk) disable iff (rst)
        (mask_o == 4'hF) |-> (tc_o == '0));
    assert_one_tc_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(tc_o));
endmodule

// File: tb/dma_regif_bench.sv
module dma_regif_bench;
    localparam int CLK_PERIOD = 10;

    logic clk = 0, rst = 1;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic       cs = 0, wr_en = 0, rd_en = 0;
    logic [3:0] addr = 0;
    logic [7:0] wdata = 0, rdata;
    logic       step_valid = 0;
    logic [1:0] step_ch = 0;
    logic [3:0] mask_o, tc_o;
    logic [7:0] cmd_o;
    logic [23:0] mode_o;

    logic       cs_w = 0, wr_w = 0, rd_w = 0;
    logic [4:0] addr_w = 0;
    logic [7:0] rdata_w;
    logic [3:0] mask_w, tc_w;
    logic [7:0] cmd_w;
    logic [23:0] mode_w;

    dma_regif u_dma_regif (
        .clk(clk), .rst(rst), .cs(cs), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .step_valid(step_valid), .step_ch(step_ch),
        .mask_o(mask_o), .tc_o(tc_o), .cmd_o(cmd_o), .chan_mode_o(mode_o));

    dma_regif #(.WORD_SPACED(1'b1)) u_dma_regif_w (
        .clk(clk), .rst(rst), .cs(cs_w), .wr_en(wr_w), .rd_en(rd_w), .addr(addr_w),
        .wdata(wdata), .rdata(rdata_w), .step_valid(1'b0), .step_ch(2'd0),
        .mask_o(mask_w), .tc_o(tc_w), .cmd_o(cmd_w), .chan_mode_o(mode_w));

    int checks = 0, failures = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    bit         dut_q[$];

    task automatic check8(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Scoreboard monitor: compares read data mid-cycle against queued expectations.
    always @(negedge clk) begin
        if ((cs && rd_en) || (cs_w && rd_w)) begin
            if (exp_q.size() == 0) begin
                failures++;
                $display("FAIL scoreboard-empty actual=%h expected=none", rdata);
            end else begin
                logic [7:0] e;
                string t;
                bit w;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                w = dut_q.pop_front();
                check8(w ? rdata_w : rdata, e, t);
            end
        end
    end

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(posedge clk); #1; cs = 1; wr_en = 1; addr = a; wdata = d;
        @(posedge clk); #1; cs = 0; wr_en = 0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [7:0] e, input string tag);
        exp_q.push_back(e); tag_q.push_back(tag); dut_q.push_back(1'b0);
        @(posedge clk); #1; cs = 1; rd_en = 1; addr = a;
        @(posedge clk); #1; cs = 0; rd_en = 0;
    endtask

    task automatic wr_w_t(input logic [4:0] a, input logic [7:0] d);
        @(posedge clk); #1; cs_w = 1; wr_w = 1; addr_w = a; wdata = d;
        @(posedge clk); #1; cs_w = 0; wr_w = 0;
    endtask

    task automatic rd_w_t(input logic [4:0] a, input logic [7:0] e, input string tag);
        exp_q.push_back(e); tag_q.push_back(tag); dut_q.push_back(1'b1);
        @(posedge clk); #1; cs_w = 1; rd_w = 1; addr_w = a;
        @(posedge clk); #1; cs_w = 0; rd_w = 0;
    endtask

    task automatic step(input logic [1:0] ch);
        @(posedge clk); #1; step_valid = 1; step_ch = ch;
        @(posedge clk); #1; step_valid = 0;
    endtask

    bit done = 0;
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        // R1 reset state
        check8({4'h0, mask_o}, 8'h0F, "R1 mask after reset");
        rd(4'h8, 8'h00, "R1 status after reset");
        rd(4'h0, 8'h00, "R1 pointer low after reset");
        rd(4'h0, 8'h00, "R1 pointer pair");

        // R2 address write/read on channel 1
        wr(4'hC, 8'h00);
        wr(4'h2, 8'h34); wr(4'h2, 8'h12);
        rd(4'h2, 8'h34, "R2 addr lo"); rd(4'h2, 8'h12, "R2 addr hi");
        wr(4'h3, 8'h02); wr(4'h3, 8'h00);

        // R3 pointer toggle and clear on channel 0
        wr(4'h0, 8'hAA);
        wr(4'hC, 8'h00);
        wr(4'h0, 8'h55); wr(4'h0, 8'h66);
        rd(4'h0, 8'h55, "R3 lo after clear"); rd(4'h0, 8'h66, "R3 hi after toggle");

        // R4 mode ch1 (single, increment, no autoinit) and unmask ch1
        wr(4'hB, 8'h45);
        wr(4'hA, 8'h01);
        check8({4'h0, mask_o}, 8'h0D, "R4 unmask ch1");
        wr(4'hA, 8'h06);
        check8({4'h0, mask_o}, 8'h0D, "R4 mask ch2 already set");

        // R7 one increment step
        step(2'd1);
        rd(4'h2, 8'h35, "R7 addr incremented"); rd(4'h2, 8'h12, "R7 addr hi");
        rd(4'h3, 8'h01, "R7 count decremented"); rd(4'h3, 8'h00, "R7 count hi");

        // R11 step to masked channel 2 is ignored
        step(2'd2);
        rd(4'h5, 8'h00, "R11 masked count lo"); rd(4'h5, 8'h00, "R11 masked count hi");
        rd(4'h8, 8'h00, "R11 no tc on masked channel");

        // R8 terminal count without autoinit
        step(2'd1); step(2'd1);
        rd(4'h3, 8'hFF, "R8 count wrapped lo"); rd(4'h3, 8'hFF, "R8 count wrapped hi");
        rd(4'h2, 8'h37, "R8 addr lo"); rd(4'h2, 8'h12, "R8 addr hi");
        check8({4'h0, mask_o}, 8'h0F, "R8 self-mask ch1");
        rd(4'h8, 8'h02, "R9 tc flag ch1");
        rd(4'h8, 8'h00, "R9 cleared on read");

        // R8 autoinit, decrement (R7) on channel 3
        wr(4'hB, 8'h7B);
        wr(4'h6, 8'h10); wr(4'h6, 8'h00);
        wr(4'h7, 8'h01); wr(4'h7, 8'h00);
        wr(4'hA, 8'h03);
        step(2'd3);
        rd(4'h6, 8'h0F, "R7 addr decremented"); rd(4'h6, 8'h00, "R7 dec hi");
        step(2'd3);
        rd(4'h6, 8'h10, "R8 autoinit addr reload"); rd(4'h6, 8'h00, "R8 reload hi");
        rd(4'h7, 8'h01, "R8 autoinit count reload"); rd(4'h7, 8'h00, "R8 count hi");
        check8({4'h0, mask_o}, 8'h07, "R8 autoinit keeps unmasked");
        rd(4'h8, 8'h08, "R9 tc flag ch3");

        // R10 request register
        wr(4'h9, 8'h06);
        rd(4'h8, 8'h40, "R10 request ch2 set");
        wr(4'h9, 8'h02);
        rd(4'h8, 8'h00, "R10 request ch2 cleared");

        // R11 controller disable
        wr(4'h8, 8'h04);
        check8(cmd_o, 8'h04, "R11 command written");
        step(2'd3);
        rd(4'h6, 8'h10, "R11 disabled no step"); rd(4'h6, 8'h00, "R11 disabled hi");
        wr(4'h8, 8'h00);

        // R5 mask-all and clear-mask
        wr(4'hF, 8'h05);
        check8({4'h0, mask_o}, 8'h05, "R5 mask-all");
        wr(4'hE, 8'h00);
        check8({4'h0, mask_o}, 8'h00, "R5 clear-mask");

        // R6 master clear
        wr(4'h9, 8'h04);
        wr(4'h8, 8'h81);
        wr(4'h0, 8'h99);
        wr(4'hD, 8'h00);
        check8({4'h0, mask_o}, 8'h0F, "R6 masks set");
        check8(cmd_o, 8'h00, "R6 command cleared");
        rd(4'h8, 8'h00, "R6 status and request cleared");
        rd(4'h0, 8'h99, "R6 pointer cleared"); rd(4'h0, 8'h66, "R6 pointer pair");
        rd(4'hD, 8'h00, "R6 temp reads zero");

        // R12 word-spaced variant
        wr_w_t(5'h18, 8'h00);
        wr_w_t(5'h04, 8'hAB); wr_w_t(5'h04, 8'hCD);
        rd_w_t(5'h04, 8'hAB, "R12 word addr lo"); rd_w_t(5'h04, 8'hCD, "R12 word addr hi");
        wr_w_t(5'h1F, 8'h00);
        check8({4'h0, mask_w}, 8'h0F, "R12 odd address ignored");
        wr_w_t(5'h1E, 8'h00);
        check8({4'h0, mask_w}, 8'h00, "R12 mask-all at doubled offset");

        repeat (2) @(posedge clk);
        if (exp_q.size() != 0) begin
            failures++;
            $display("FAIL scoreboard-leftover actual=%0d expected=0", exp_q.size());
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule